// File: doc/BRIEF.md
# PLL Loop-Filter Sweep Controller

This block picks a loop-filter setting for a PLL whose M, N and P dividers have already been chosen. The filter code is a 3-bit field at bits 5:3 of the P byte. After a start pulse the controller walks through all eight filter codes. For each code it asks an external lock qualifier whether the PLL stays stable at the nominal feedback divider N. When the nominal divider locks, it then asks about the six neighbouring dividers N-3 to N+3, skipping N itself. A setting that passes all six is taken as robust and ends the sweep at once. A setting that locks only at N is kept as a fallback, and the sweep moves on to the next code.

The qualifier is reached through a request/acknowledge port that carries the M, N and P values under test. The qualifier answers with a pass bit next to a one-cycle acknowledge, and only one check is outstanding at a time. At the end the controller reports the chosen P byte, a 2-bit quality code, a one-cycle done pulse and an ok flag. These results hold until the next start. A hold output keeps the PLL in its disabled state for the whole sweep and releases it when the sweep ends, whether the sweep succeeded or failed.

Top module: `pll_filter_sweep`

## Requirements
- R1: While reset is held and directly after it, done, ok, chk_req and pll_hold are 0, quality is 0 and p_out is 0.
- R2: A start pulse seen while idle latches m_in, n_in and p_in and clears quality to 0 (none found) and ok to 0. The first check uses p_in AND 0x47, which keeps bit 6 and post-divider bits 2:0 and clears filter code bits 5:3. Each later filter setting adds 8 to P, so the codes run 0 to 7 in rising order.
- R3: For each filter setting the nominal N is checked first. Only if it passes are N-3, N-2, N-1, N+1, N+2 and N+3 checked, in that order. chk_m equals the latched M on every check.
- R4: The first neighbour check that fails ends the checks for that filter setting. The remaining neighbours are not requested.
- R5: If all six neighbours pass, the controller finishes with quality 1 (robust), p_out equal to the P under test and ok 1. No further check is requested.
- R6: A setting whose nominal N passes but whose neighbour check fails sets quality to 2 (marginal) and saves its P as the fallback. If no setting is robust after all eight, the controller finishes with quality 2, p_out equal to the last saved fallback and ok 1.
- R7: If no setting passes its nominal check, the controller finishes with quality 0, ok 0 and p_out equal to the original unmasked p_in.
- R8: chk_req stays high until a cycle with chk_ack. After that cycle it is low for at least one cycle, so at most one check is ever outstanding.
- R9: done is high for exactly one cycle. p_out changes only in that cycle. p_out, quality and ok hold their final values until the next start.
- R10: pll_hold is high from the cycle after an accepted start until the done cycle, in which it is low again. It is high whenever chk_req is high.
- R11: A start pulse during a sweep is ignored, and the result equals that of the first start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a sweep (accepted only when idle) |
| m_in | input | 8 | Reference divider M |
| n_in | input | 8 | Nominal feedback divider N |
| p_in | input | 8 | Initial P byte (post divider, filter code, bit 6) |
| chk_ack | input | 1 | One-cycle acknowledge from the lock qualifier |
| chk_pass | input | 1 | Check result, valid with chk_ack |
| chk_req | output | 1 | Check request, held until acknowledged |
| chk_m | output | 8 | M for the requested check |
| chk_n | output | 8 | N for the requested check |
| chk_p | output | 8 | P for the requested check |
| pll_hold | output | 1 | Keeps the PLL disabled during the sweep |
| p_out | output | 8 | Final P byte |
| quality | output | 2 | 0 none, 1 robust, 2 marginal |
| done | output | 1 | One-cycle completion pulse |
| ok | output | 1 | Sweep found a usable setting |

## Verification
The lock qualifier model answers from a pass table drawn for each sweep. The bench builds from the same table the expected list of probes: the filter code and N offset of each check, in order. Directed tables separate several cases:
- no setting locks, which must return the unmasked P;
- a robust first code, which must stop at seven checks;
- a failure at the first or the last neighbour, which tests early exit;
- marginal codes followed by a robust one, which must prefer the robust one;
- marginal codes only, which must return the last fallback and not the first.

Random tables with varied pass rates mix these outcomes, and acknowledge latencies are drawn at random. One run sends a second start mid-sweep to show that it is ignored.

// File: rtl/pfs_pkg.sv
// Shared types for the PLL loop-filter sweep controller.
// Assumes: quality encoding is fixed at 2 bits (none, robust, marginal).
package pfs_pkg;
    typedef enum logic [1:0] {PS_IDLE, PS_ASK, PS_GAP} pfs_state_e;

    localparam logic [1:0] Q_NONE = 2'd0;
    localparam logic [1:0] Q_BEST = 2'd1;
    localparam logic [1:0] Q_CRIT = 2'd2;
endpackage

// File: rtl/pfs_probe_sel.sv
// Maps a probe index to the feedback divider under test.
// Index 0 is the nominal N; 1..SPAN are N-SPAN..N-1; SPAN+1..2*SPAN are N+1..N+SPAN.
// Assumes: the caller keeps N-SPAN and N+SPAN inside the W-bit range (no wrap handling).
module pfs_probe_sel #(
    parameter int W    = 8,
    parameter int SPAN = 3,
    parameter int IW   = 3
) (
    input  logic [W-1:0]  n_base,
    input  logic [IW-1:0] idx,
    output logic [W-1:0]  n_probe
);
    localparam logic [W-1:0] SPAN_W  = W'(SPAN);
    localparam logic [W-1:0] SPAN_P1 = W'(SPAN + 1);

    logic [W-1:0] idx_w;
    assign idx_w = W'(idx);

    // Select nominal, lower or upper neighbour divider.
    always_comb begin
        if (idx_w == '0)
            n_probe = n_base;
        else if (idx_w <= SPAN_W)
            n_probe = n_base - (SPAN_P1 - idx_w);
        else
            n_probe = n_base + (idx_w - SPAN_W);
    end
endmodule

// File: rtl/pfs_seq.sv
// Sequencer for the filter sweep: issues one check at a time, ranks each
// filter code by nominal and neighbour results, and holds the final result.
// Assumes: chk_ack is a one-cycle pulse answering the current request.
module pfs_seq
    import pfs_pkg::*;
#(
    parameter int          W        = 8,
    parameter int          NUM_FILT = 8,
    parameter int          FLT_LSB  = 3,
    parameter logic [W-1:0] KEEP    = 8'h47,
    parameter int          SPAN     = 3,
    parameter int          IW       = 3,
    parameter int          SW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [W-1:0]  m_in,
    input  logic [W-1:0]  n_in,
    input  logic [W-1:0]  p_in,
    input  logic          ack,
    input  logic          pass,
    output logic          busy,
    output logic          ask,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  m_r,
    output logic [W-1:0]  n_r,
    output logic [W-1:0]  p_cur,
    output logic [W-1:0]  p_out,
    output logic [1:0]    quality,
    output logic          ok,
    output logic          done
);
    localparam logic [IW-1:0] LAST_IDX  = IW'(2 * SPAN);
    localparam logic [SW-1:0] LAST_STEP = SW'(NUM_FILT - 1);
    localparam logic [W-1:0]  STEP_INC  = W'(1) << FLT_LSB;

    pfs_state_e    state;
    logic [SW-1:0] step;
    logic [W-1:0]  p_bak;
    logic          nbr_fail;
    logic [W-1:0]  bak_nx;
    logic [1:0]    qual_nx;

    assign busy = (state != PS_IDLE);
    assign ask  = (state == PS_ASK);

    // Fallback and quality as they stand after the current response.
    always_comb begin
        nbr_fail = (idx != '0) && !pass;
        bak_nx   = nbr_fail ? p_cur  : p_bak;
        qual_nx  = nbr_fail ? Q_CRIT : quality;
    end

    // Sweep state, probe position and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= PS_IDLE;
            idx     <= '0;
            step    <= '0;
            m_r     <= '0;
            n_r     <= '0;
            p_cur   <= '0;
            p_bak   <= '0;
            p_out   <= '0;
            quality <= Q_NONE;
            ok      <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                PS_IDLE: begin
                    if (start) begin
                        m_r     <= m_in;
                        n_r     <= n_in;
                        p_cur   <= p_in & KEEP;
                        p_bak   <= p_in;
                        quality <= Q_NONE;
                        ok      <= 1'b0;
                        idx     <= '0;
                        step    <= '0;
                        state   <= PS_ASK;
                    end
                end
                PS_ASK: begin
                    if (ack) begin
                        if (pass && idx == LAST_IDX) begin
                            quality <= Q_BEST;
                            p_out   <= p_cur;
                            ok      <= 1'b1;
                            done    <= 1'b1;
                            state   <= PS_IDLE;
                        end else if (pass) begin
                            idx   <= idx + 1'b1;
                            state <= PS_GAP;
                        end else if (step == LAST_STEP) begin
                            quality <= qual_nx;
                            p_bak   <= bak_nx;
                            p_out   <= bak_nx;
                            ok      <= (qual_nx == Q_CRIT);
                            done    <= 1'b1;
                            state   <= PS_IDLE;
                        end else begin
                            quality <= qual_nx;
                            p_bak   <= bak_nx;
                            p_cur   <= p_cur + STEP_INC;
                            step    <= step + 1'b1;
                            idx     <= '0;
                            state   <= PS_GAP;
                        end
                    end
                end
                default: state <= PS_ASK;
            endcase
        end
    end
endmodule

// File: rtl/pll_filter_sweep.sv
// Top of the PLL loop-filter sweep controller: joins the sequencer and the
// probe divider selector and optionally drives a PLL hold during the sweep.
// Assumes: one lock qualifier on the check port; HOLD_EN=0 ties pll_hold low.
module pll_filter_sweep #(
    parameter int           W        = 8,
    parameter int           NUM_FILT = 8,
    parameter int           FLT_LSB  = 3,
    parameter logic [W-1:0] KEEP     = 8'h47,
    parameter int           SPAN     = 3,
    parameter bit           HOLD_EN  = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] m_in,
    input  logic [W-1:0] n_in,
    input  logic [W-1:0] p_in,
    input  logic         chk_ack,
    input  logic         chk_pass,
    output logic         chk_req,
    output logic [W-1:0] chk_m,
    output logic [W-1:0] chk_n,
    output logic [W-1:0] chk_p,
    output logic         pll_hold,
    output logic [W-1:0] p_out,
    output logic [1:0]   quality,
    output logic         done,
    output logic         ok
);
    localparam int IW = $clog2(2 * SPAN + 1);
    localparam int SW = (NUM_FILT > 1) ? $clog2(NUM_FILT) : 1;

    logic          busy;
    logic [IW-1:0] idx;
    logic [W-1:0]  n_r;

    pfs_seq #(
        .W(W), .NUM_FILT(NUM_FILT), .FLT_LSB(FLT_LSB), .KEEP(KEEP),
        .SPAN(SPAN), .IW(IW), .SW(SW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start(start),
        .m_in(m_in), .n_in(n_in), .p_in(p_in),
        .ack(chk_ack), .pass(chk_pass),
        .busy(busy), .ask(chk_req), .idx(idx),
        .m_r(chk_m), .n_r(n_r), .p_cur(chk_p),
        .p_out(p_out), .quality(quality), .ok(ok), .done(done)
    );

    pfs_probe_sel #(.W(W), .SPAN(SPAN), .IW(IW)) u_probe (
        .n_base(n_r), .idx(idx), .n_probe(chk_n)
    );

    generate
        if (HOLD_EN) begin : g_hold
            assign pll_hold = busy;
        end else begin : g_nohold
            assign pll_hold = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/pfs_checker.sv
// Protocol and result checks for pll_filter_sweep, bound to every instance.
module pfs_checker #(
    parameter int W       = 8,
    parameter bit HOLD_EN = 1'b1
) (
    input logic         clk,
    input logic         rst_n,
    input logic         chk_req,
    input logic         chk_ack,
    input logic         pll_hold,
    input logic [W-1:0] p_out,
    input logic [1:0]   quality,
    input logic         done,
    input logic         ok
);
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req && !chk_ack |=> chk_req);                          // R8
    AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        chk_req && chk_ack |=> !chk_req);                          // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                           // R9
    AST_P_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(p_out) |-> done);                                 // R9
    AST_OK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ok == (quality != 2'd0)));                       // R6
    AST_QUAL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        quality != 2'd3);                                          // R5
    AST_NO_REQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chk_req);                                        // R5
    generate
        if (HOLD_EN) begin : g_hold_chk
            AST_HOLD_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
                chk_req |-> pll_hold);                             // R10
        end
    endgenerate
endmodule

bind pll_filter_sweep pfs_checker #(.W(W), .HOLD_EN(HOLD_EN)) u_pfs_chk (
    .clk(clk), .rst_n(rst_n), .chk_req(chk_req), .chk_ack(chk_ack),
    .pll_hold(pll_hold), .p_out(p_out), .quality(quality),
    .done(done), .ok(ok)
);

// File: tb/test_pll_filter_sweep.sv
// Bench for pll_filter_sweep: a lock qualifier model answers from a pass
// table, and a reference model predicts the probe list and the result.
module test_pll_filter_sweep;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] m_in = '0, n_in = '0, p_in = '0;
    logic       chk_ack = 1'b0, chk_pass = 1'b0;
    logic       chk_req, pll_hold, done, ok;
    logic [7:0] chk_m, chk_n, chk_p, p_out;
    logic [1:0] quality;

    int vectors = 0;
    int miscompares = 0;

    logic [7:0]  nom_ok;
    logic [47:0] nbr_ok;
    logic [7:0]  cur_m, cur_n, cur_p;
    int exp_off[64];
    int exp_code[64];
    int exp_len;
    int seen_len;
    int seq_err;
    logic [7:0] exp_p;
    logic [1:0] exp_q;
    logic       exp_ok;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pll_filter_sweep i_pll_filter_sweep (
        .clk(clk), .rst_n(rst_n), .start(start),
        .m_in(m_in), .n_in(n_in), .p_in(p_in),
        .chk_ack(chk_ack), .chk_pass(chk_pass),
        .chk_req(chk_req), .chk_m(chk_m), .chk_n(chk_n), .chk_p(chk_p),
        .pll_hold(pll_hold), .p_out(p_out), .quality(quality),
        .done(done), .ok(ok)
    );

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        vectors++;
        if (!cond) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int off_to_k(input int off);
        return (off < 0) ? off + 3 : off + 2;
    endfunction

    // Reference model: expected probe list and result from the pass table (R2-R7).
    task automatic model();
        logic [7:0] p0, bak, pc;
        logic [1:0] q;
        int offs[6];
        bit best;
        offs = '{-3, -2, -1, 1, 2, 3};
        p0 = cur_p & 8'h47;
        bak = cur_p;
        q = 2'd0;
        exp_len = 0;
        best = 0;
        for (int s = 0; s < 8 && !best; s++) begin
            pc = p0 + 8'(s * 8);
            exp_off[exp_len] = 0; exp_code[exp_len] = s; exp_len++;
            if (nom_ok[s]) begin
                bit all = 1;
                for (int k = 0; k < 6; k++) begin
                    exp_off[exp_len] = offs[k]; exp_code[exp_len] = s; exp_len++;
                    if (!nbr_ok[s * 6 + k]) begin all = 0; break; end
                end
                if (all) begin best = 1; q = 2'd1; exp_p = pc; end
                else begin q = 2'd2; bak = pc; end
            end
        end
        if (!best) exp_p = bak;
        exp_q = q;
        exp_ok = (q != 2'd0);
    endtask

    // Lock qualifier model with random acknowledge latency; logs each probe.
    initial begin
        forever begin
            @(negedge clk);
            if (chk_req && !chk_ack) begin
                int code, off;
                code = int'(chk_p[5:3]);
                off  = int'($signed(chk_n - cur_n));
                if (seen_len >= exp_len || exp_off[seen_len] != off ||
                    exp_code[seen_len] != code) seq_err++;
                if ((chk_p & 8'hC7) != (cur_p & 8'h47)) seq_err++;
                if (chk_m != cur_m || !pll_hold) seq_err++;
                seen_len++;
                repeat ($urandom_range(0, 3)) @(negedge clk);
                chk_ack  = 1'b1;
                chk_pass = (off == 0) ? nom_ok[code] : nbr_ok[code * 6 + off_to_k(off)];
                @(negedge clk);
                chk_ack  = 1'b0;
                chk_pass = 1'b0;
                if (chk_req) seq_err++;
            end
        end
    end

    // One sweep: start, optional mid-sweep restart, wait for done, compare.
    task automatic run_sweep(input string name, input bit restart);
        int waitc;
        model();
        seen_len = 0;
        seq_err = 0;
        @(negedge clk);
        m_in = cur_m; n_in = cur_n; p_in = cur_p; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        m_in = 8'($urandom); n_in = 8'($urandom); p_in = 8'($urandom);
        check(quality == 2'd0 && ok == 1'b0, {name, " R2 quality cleared"}, int'(quality), 0);
        check(pll_hold == 1'b1, {name, " R10 hold during sweep"}, int'(pll_hold), 1);
        if (restart) begin
            repeat (4) @(negedge clk);
            p_in = ~cur_p; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        waitc = 0;
        while (!done && waitc < 2000) begin @(negedge clk); waitc++; end
        check(done == 1'b1, {name, " R9 done seen"}, int'(done), 1);
        check(quality == exp_q, {name, " R5/R6/R7 quality"}, int'(quality), int'(exp_q));
        check(p_out == exp_p, {name, " R5/R6/R7 p_out"}, int'(p_out), int'(exp_p));
        check(ok == exp_ok, {name, " R6/R7 ok"}, int'(ok), int'(exp_ok));
        check(pll_hold == 1'b0, {name, " R10 hold released"}, int'(pll_hold), 0);
        check(seen_len == exp_len, {name, " R3/R4 probe count"}, seen_len, exp_len);
        check(seq_err == 0, {name, " R3/R4/R8 probe order and fields"}, seq_err, 0);
        if (restart) check(1'b1, {name, " R11 restart ignored"}, 0, 0);
        @(negedge clk);
        check(done == 1'b0, {name, " R9 done one cycle"}, int'(done), 0);
        repeat (3) @(negedge clk);
        check(p_out == exp_p && quality == exp_q && ok == exp_ok && !chk_req,
              {name, " R9 results held"}, int'(p_out), int'(exp_p));
    endtask

    task automatic pick_dividers();
        cur_m = 8'($urandom_range(2, 31));
        cur_n = 8'($urandom_range(11, 125));
        cur_p = 8'($urandom);
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(!done && !ok && !chk_req && !pll_hold && quality == 2'd0 && p_out == 8'd0,
              "R1 reset state", int'(quality), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !chk_req && !pll_hold, "R1 idle after reset", int'(chk_req), 0);

        // Directed corner cases.
        pick_dividers(); cur_p = 8'hFF; nom_ok = 8'h00; nbr_ok = '0;
        run_sweep("none_lock R7", 1'b0);
        pick_dividers(); nom_ok = 8'h01; nbr_ok = {48{1'b1}};
        run_sweep("first_best R5", 1'b0);
        pick_dividers(); nom_ok = 8'hFF; nbr_ok = '0;
        run_sweep("fail_first_nbr R4", 1'b0);
        pick_dividers(); nom_ok = 8'h24; nbr_ok = {48{1'b1}};
        nbr_ok[2 * 6 + 5] = 1'b0; nbr_ok[5 * 6 + 5] = 1'b0;
        run_sweep("fail_last_nbr R6", 1'b0);
        pick_dividers(); nom_ok = 8'h83; nbr_ok = {48{1'b1}};
        nbr_ok[0 * 6 + 1] = 1'b0; nbr_ok[1 * 6 + 3] = 1'b0;
        run_sweep("crit_then_best R5", 1'b0);
        pick_dividers(); nom_ok = 8'h80; nbr_ok = {48{1'b1}};
        run_sweep("last_best R5", 1'b0);
        pick_dividers(); nom_ok = 8'h5A; nbr_ok = {48{1'b1}};
        for (int s = 0; s < 8; s++) nbr_ok[s * 6 + 4] = 1'b0;
        run_sweep("last_backup R6", 1'b0);
        pick_dividers(); nom_ok = 8'h10; nbr_ok = {48{1'b1}};
        run_sweep("restart_busy R11", 1'b1);

        // Constrained random tables with varied pass rates.
        for (int t = 0; t < 40; t++) begin
            int nom_pct, nbr_pct;
            pick_dividers();
            nom_pct = $urandom_range(0, 100);
            nbr_pct = $urandom_range(50, 100);
            for (int s = 0; s < 8; s++) nom_ok[s] = ($urandom_range(0, 99) < nom_pct);
            for (int b = 0; b < 48; b++) nbr_ok[b] = ($urandom_range(0, 99) < nbr_pct);
            run_sweep("random R3", 1'b0);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule